// File: doc/BRIEF.md
# Configurable Test Sequence Generator

This block is a streaming source of test data for link self-test. Whenever it is enabled and its request input is high, it sends one W-bit word together with a valid flag. Three kinds of data are available: a pseudo-random shift-register sequence, an incrementing counter that wraps at a programmable modulo, or a fixed word. The request input can be tied to a downstream ready, so the generator fills every slot the sink accepts. It can also be tied to an upstream valid, so that generated words replace user data at the user's pace.

Five control inputs set the behaviour: an enable, a counter/pseudo-random select, a fixed-word select, a 32-bit starting value and a 32-bit modulo. A 32-bit counter reports how many words have been sent since the generator was last enabled. A parameter chooses between a registered output stage, which adds one cycle of latency, and outputs driven directly from the sequence state.

Top module: `test_seq_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_val` becomes 0 and `tx_cnt` becomes 0. The reset is synchronous and active high.
- R2: While `en` is low, `out_val` stays 0 and the sequence state is loaded from `init_val`. With LATENCY=1, `out_dat` shows the low W bits of `init_val` from the cycle after a rising edge where `en` was low.
- R3: The first word sent after `en` rises is the low W bits of `init_val`. Each later word is the successor of the previous state in the selected sequence.
- R4: With `mode_cnt`=0 the state is a Fibonacci shift register. The next value is `{cur[W-2:0], fb}`, where `fb` is the XOR of the tapped bits. For W=16 the tapped bits are 15, 14, 12 and 3. An all-zero state steps to the value 1, so the sequence cannot lock up.
- R5: With `mode_cnt`=1 the state steps by 1. When the modulo m (the low W bits of `mod_val`) is nonzero and cur+1 >= m, the state returns to 0. When m is 0, the state wraps naturally at 2^W.
- R6: While `const_sel`=1, every word sent carries the low W bits of `init_val`, whatever `mode_cnt` is. The sequence state keeps advancing underneath.
- R7: A word is sent, and the state advances, in exactly those cycles where `en` and `req` are both high. In cycles without a request the state holds.
- R8: `tx_cnt` increases by 1 at each rising edge where `en` and `req` are both high. It is cleared at every edge where `en` is low, and it wraps at 2^32.
- R9: With LATENCY=1, `out_val` and `out_dat` appear one cycle after the request cycle. With LATENCY=0, they appear in the same cycle as the request.
- R10: Bits of `init_val` and `mod_val` above bit W-1 have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run the generator; when low, hold it at its starting value |
| mode_cnt | input | 1 | 1 selects the counter, 0 selects the pseudo-random sequence |
| const_sel | input | 1 | 1 sends the starting value as a fixed word |
| init_val | input | 32 | Starting value and fixed word |
| mod_val | input | 32 | Counter modulo (0 means 2^W) |
| req | input | 1 | Request for one word in this cycle |
| out_dat | output | W | Generated data word |
| out_val | output | 1 | Word on `out_dat` is valid |
| tx_cnt | output | 32 | Words sent since enable went active |

## Verification
Two functions of this block can land in the same cycle: a request and the fall of enable. A request in the cycle where enable drops must not send a word. The counter must clear rather than increment, and the data register must reload the starting value. The bench provokes this case by driving `en` low with `req` still high at the end of a pseudo-random run. It judges the result through the scoreboard at the ports: it expects `out_val` low, `tx_cnt` equal to 0 and `out_dat` equal to the starting value. A second collision is the counter wrap at the modulo coinciding with a gap in the requests. This is covered by irregular request patterns in counter mode.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

   localparam int CFG_W = 32;   // width of init/modulo inputs
   localparam int CNT_W = 32;   // width of the transmit counter

   // maximal-length feedback taps, bit n-1 set for tap n
   function automatic logic [31:0] tap_mask(input int w);
      logic [31:0] m;
      m = '0;
      case (w)
         4:  begin m[3] = 1'b1; m[2] = 1'b1; end
         5:  begin m[4] = 1'b1; m[2] = 1'b1; end
         6:  begin m[5] = 1'b1; m[4] = 1'b1; end
         7:  begin m[6] = 1'b1; m[5] = 1'b1; end
         8:  begin m[7] = 1'b1; m[5] = 1'b1; m[4] = 1'b1; m[3] = 1'b1; end
         9:  begin m[8] = 1'b1; m[4] = 1'b1; end
         10: begin m[9] = 1'b1; m[6] = 1'b1; end
         11: begin m[10] = 1'b1; m[8] = 1'b1; end
         12: begin m[11] = 1'b1; m[5] = 1'b1; m[3] = 1'b1; m[0] = 1'b1; end
         13: begin m[12] = 1'b1; m[3] = 1'b1; m[2] = 1'b1; m[0] = 1'b1; end
         14: begin m[13] = 1'b1; m[4] = 1'b1; m[2] = 1'b1; m[0] = 1'b1; end
         15: begin m[14] = 1'b1; m[13] = 1'b1; end
         16: begin m[15] = 1'b1; m[14] = 1'b1; m[12] = 1'b1; m[3] = 1'b1; end
         17: begin m[16] = 1'b1; m[13] = 1'b1; end
         18: begin m[17] = 1'b1; m[10] = 1'b1; end
         19: begin m[18] = 1'b1; m[5] = 1'b1; m[1] = 1'b1; m[0] = 1'b1; end
         20: begin m[19] = 1'b1; m[16] = 1'b1; end
         21: begin m[20] = 1'b1; m[18] = 1'b1; end
         22: begin m[21] = 1'b1; m[20] = 1'b1; end
         23: begin m[22] = 1'b1; m[17] = 1'b1; end
         24: begin m[23] = 1'b1; m[22] = 1'b1; m[21] = 1'b1; m[16] = 1'b1; end
         25: begin m[24] = 1'b1; m[21] = 1'b1; end
         26: begin m[25] = 1'b1; m[5] = 1'b1; m[1] = 1'b1; m[0] = 1'b1; end
         27: begin m[26] = 1'b1; m[4] = 1'b1; m[1] = 1'b1; m[0] = 1'b1; end
         28: begin m[27] = 1'b1; m[24] = 1'b1; end
         29: begin m[28] = 1'b1; m[26] = 1'b1; end
         30: begin m[29] = 1'b1; m[5] = 1'b1; m[3] = 1'b1; m[0] = 1'b1; end
         31: begin m[30] = 1'b1; m[27] = 1'b1; end
         32: begin m[31] = 1'b1; m[21] = 1'b1; m[1] = 1'b1; m[0] = 1'b1; end
         default: m = '0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/tsg_lfsr_next.sv
module tsg_lfsr_next
   import tsg_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] cur,
   output logic [W-1:0] nxt
);
   localparam logic [31:0] MASK_FULL = tap_mask(W);
   localparam logic [W-1:0] MASK = MASK_FULL[W-1:0];
   localparam logic [W-1:0] ESCAPE = {{(W-1){1'b0}}, 1'b1};

   logic fb;

   always_comb begin
      fb = ^(cur & MASK);
      if (cur == '0) nxt = ESCAPE;
      else           nxt = {cur[W-2:0], fb};
   end
endmodule

// File: rtl/tsg_cnt_next.sv
module tsg_cnt_next #(
   parameter int W = 16
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] modv,
   output logic [W-1:0] nxt
);
   logic [W:0] inc;

   always_comb begin
      inc = {1'b0, cur} + {{W{1'b0}}, 1'b1};
      if (modv != '0 && inc >= {1'b0, modv}) nxt = '0;
      else                                    nxt = inc[W-1:0];
   end
endmodule

// File: rtl/tsg_tx_counter.sv
module tsg_tx_counter #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr,
   input  logic          inc,
   output logic [CW-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (rst || clr) cnt <= '0;
      else if (inc)   cnt <= cnt + {{(CW-1){1'b0}}, 1'b1};
   end
endmodule

// File: rtl/test_seq_gen.sv
module test_seq_gen
   import tsg_pkg::*;
#(
   parameter int W       = 16,
   parameter int LATENCY = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             mode_cnt,
   input  logic             const_sel,
   input  logic [CFG_W-1:0] init_val,
   input  logic [CFG_W-1:0] mod_val,
   input  logic             req,
   output logic [W-1:0]     out_dat,
   output logic             out_val,
   output logic [CNT_W-1:0] tx_cnt
);
   generate
      if (W < 4 || W > 32) begin : g_bad_width
         $error("test_seq_gen: W must lie in 4..32");
      end
      if (LATENCY != 0 && LATENCY != 1) begin : g_bad_lat
         $error("test_seq_gen: LATENCY must be 0 or 1");
      end
   endgenerate

   logic [W-1:0] init_w, mod_w;
   logic [W-1:0] seq_q, seq_nxt, lfsr_nxt, cnt_nxt, word;
   logic         fire;

   assign init_w = init_val[W-1:0];
   assign mod_w  = mod_val[W-1:0];
   assign fire   = en & req;

   tsg_lfsr_next #(.W(W)) u_lfsr (
      .cur (seq_q),
      .nxt (lfsr_nxt)
   );

   tsg_cnt_next #(.W(W)) u_cnt (
      .cur  (seq_q),
      .modv (mod_w),
      .nxt  (cnt_nxt)
   );

   assign seq_nxt = mode_cnt ? cnt_nxt : lfsr_nxt;
   assign word    = const_sel ? init_w : seq_q;

   always_ff @(posedge clk) begin
      if (rst)       seq_q <= '0;
      else if (!en)  seq_q <= init_w;
      else if (fire) seq_q <= seq_nxt;
   end

   generate
      if (LATENCY == 1) begin : g_reg_out
         logic [W-1:0] dat_q;
         logic         val_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               dat_q <= '0;
               val_q <= 1'b0;
            end else begin
               val_q <= fire;
               if (!en)       dat_q <= init_w;
               else if (fire) dat_q <= word;
            end
         end
         assign out_dat = dat_q;
         assign out_val = val_q;
      end else begin : g_comb_out
         assign out_dat = word;
         assign out_val = fire;
      end
   endgenerate

   tsg_tx_counter #(.CW(CNT_W)) u_txc (
      .clk (clk),
      .rst (rst),
      .clr (~en),
      .inc (fire),
      .cnt (tx_cnt)
   );
endmodule

// File: rtl/tsg_checker.sv
module tsg_checker #(
   parameter int W       = 16,
   parameter int LATENCY = 1
) (
   input logic          clk,
   input logic          rst,
   input logic          en,
   input logic          const_sel,
   input logic [31:0]   init_val,
   input logic          req,
   input logic [W-1:0]  out_dat,
   input logic          out_val,
   input logic [31:0]   tx_cnt
);
   // R8: counter cleared after a disabled edge
   a_r8_cnt_clear: assert property (@(posedge clk) disable iff (rst)
      !en |=> tx_cnt == 32'd0);

   // R8: one increment per request while enabled
   a_r8_cnt_inc: assert property (@(posedge clk) disable iff (rst)
      (en && req) |=> tx_cnt == $past(tx_cnt) + 32'd1);

   // R7: no request, no change of the counter
   a_r7_cnt_hold: assert property (@(posedge clk) disable iff (rst)
      (en && !req) |=> $stable(tx_cnt));

   generate
      if (LATENCY == 1) begin : g_lat1
         // R9: valid follows a request by one cycle
         a_r9_val_follows: assert property (@(posedge clk) disable iff (rst)
            (en && req) |=> out_val);
         // R2: no valid without an enabled request
         a_r2_no_val_idle: assert property (@(posedge clk) disable iff (rst)
            !(en && req) |=> !out_val);
         // R6: fixed-word mode sends the starting value
         a_r6_const_word: assert property (@(posedge clk) disable iff (rst)
            (en && req && const_sel) |=> out_dat == $past(init_val[W-1:0]));
      end else begin : g_lat0
         // R2: no valid while disabled
         a_r2_no_val_idle: assert property (@(posedge clk) disable iff (rst)
            !en |-> !out_val);
      end
   endgenerate
endmodule

bind test_seq_gen tsg_checker #(.W(W), .LATENCY(LATENCY)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .en        (en),
   .const_sel (const_sel),
   .init_val  (init_val),
   .req       (req),
   .out_dat   (out_dat),
   .out_val   (out_val),
   .tx_cnt    (tx_cnt)
);

// File: tb/sim_test_seq_gen.sv
`timescale 1ns/1ps
module sim_test_seq_gen;
   localparam int W = 16;

   typedef struct {
      logic          val;
      logic          chk_dat;
      logic [W-1:0]  dat;
      logic [31:0]   cnt;
      string         tag;
   } item_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en = 1'b0, mode_cnt = 1'b0, const_sel = 1'b0, req = 1'b0;
   logic [31:0] init_val = '0, mod_val = '0;

   logic [W-1:0] dat0, dat1;
   logic         val0, val1;
   logic [31:0]  cnt0, cnt1;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   item_t sb[$];
   logic [W-1:0] mdl = '0;
   logic [31:0]  mcnt = '0;

   always #2 clk = ~clk;

   test_seq_gen #(.W(W), .LATENCY(1)) u0 (
      .clk(clk), .rst(rst), .en(en), .mode_cnt(mode_cnt), .const_sel(const_sel),
      .init_val(init_val), .mod_val(mod_val), .req(req),
      .out_dat(dat0), .out_val(val0), .tx_cnt(cnt0));

   test_seq_gen #(.W(W), .LATENCY(0)) u1 (
      .clk(clk), .rst(rst), .en(en), .mode_cnt(mode_cnt), .const_sel(const_sel),
      .init_val(init_val), .mod_val(mod_val), .req(req),
      .out_dat(dat1), .out_val(val1), .tx_cnt(cnt1));

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] nxt_lfsr(input logic [W-1:0] c);
      if (c == '0) return 16'h0001;
      return {c[14:0], c[15] ^ c[14] ^ c[12] ^ c[3]};
   endfunction

   function automatic logic [W-1:0] nxt_cnt(input logic [W-1:0] c, input logic [W-1:0] m);
      logic [W:0] s;
      s = {1'b0, c} + 17'd1;
      if (m != '0 && s >= {1'b0, m}) return '0;
      return s[W-1:0];
   endfunction

   // driver: applies one cycle and records what must appear
   task automatic step(input logic e, input logic m, input logic c,
                       input logic [31:0] iv, input logic [31:0] mv,
                       input logic r, input string tag);
      item_t it;
      logic [W-1:0] t, ew;
      logic f;
      @(negedge clk);
      en = e; mode_cnt = m; const_sel = c; init_val = iv; mod_val = mv; req = r;
      #0.5;
      f  = e & r;
      t  = iv[W-1:0];
      ew = c ? t : mdl;
      // R9: combinational variant answers in the request cycle
      check(val1 == f, {tag, " R9 lat0 valid"}, {31'd0, val1}, {31'd0, f});
      if (f) check(dat1 == ew, {tag, " R9 lat0 data"}, {16'd0, dat1}, {16'd0, ew});
      it.val = f;
      it.chk_dat = f | ~e;
      it.dat = f ? ew : t;
      if (!e) begin
         mdl = t; mcnt = '0;
      end else if (f) begin
         mdl = m ? nxt_cnt(mdl, mv[W-1:0]) : nxt_lfsr(mdl);
         mcnt = mcnt + 32'd1;
      end
      it.cnt = mcnt;
      it.tag = tag;
      sb.push_back(it);
   endtask

   // monitor: compares the registered variant after each edge
   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         check(val0 == it.val, {it.tag, " valid"}, {31'd0, val0}, {31'd0, it.val});
         if (it.chk_dat)
            check(dat0 == it.dat, {it.tag, " data"}, {16'd0, dat0}, {16'd0, it.dat});
         check(cnt0 == it.cnt, {it.tag, " R8 tx_cnt"}, cnt0, it.cnt);
         check(cnt1 == it.cnt, {it.tag, " R8 tx_cnt lat0"}, cnt1, it.cnt);
      end
   end

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #400000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check(val0 == 1'b0, "R1 reset valid", {31'd0, val0}, 32'd0);
      check(cnt0 == 32'd0, "R1 reset tx_cnt", cnt0, 32'd0);
      check(cnt1 == 32'd0, "R1 reset tx_cnt lat0", cnt1, 32'd0);
      rst = 1'b0;

      // R2 and R10: disabled, upper init bits ignored
      for (int i = 0; i < 3; i++) step(0, 0, 0, 32'hABCD_1234, 0, 1, "R2_R10 idle");
      // R3 first word then R4 pseudo-random run
      for (int i = 0; i < 20; i++) step(1, 0, 0, 32'hABCD_1234, 0, 1, "R3_R4 lfsr");
      // R7: gaps in the request
      for (int i = 0; i < 12; i++) step(1, 0, 0, 32'hABCD_1234, 0, (i % 3) != 0, "R7 paced");
      // collision: enable falls while request is high
      step(0, 0, 0, 32'hABCD_1234, 0, 1, "R2_R8 en_fall");
      step(0, 1, 0, 32'h0000_FFFD, 0, 0, "R2 idle");
      // R5: natural wrap at 2^W
      for (int i = 0; i < 6; i++) step(1, 1, 0, 32'h0000_FFFD, 0, 1, "R5 wrap16");
      step(0, 1, 0, 32'h0000_0007, 32'hFFFF_000A, 0, "R2 idle");
      // R5 and R10: modulo 10, upper modulo bits ignored, irregular requests
      for (int i = 0; i < 14; i++) step(1, 1, 0, 32'h0000_0007, 32'hFFFF_000A, (i % 4) != 2, "R5_R10 mod10");
      step(0, 0, 1, 32'h0000_5A5A, 0, 0, "R2 idle");
      // R6: fixed word, then back to the running sequence
      for (int i = 0; i < 6; i++) step(1, 0, 1, 32'h0000_5A5A, 0, 1, "R6 const");
      for (int i = 0; i < 4; i++) step(1, 0, 0, 32'h0000_5A5A, 0, 1, "R6 resume");
      step(0, 0, 0, 32'h0000_0000, 0, 0, "R2 idle");
      // R4: zero seed escapes lock-up
      for (int i = 0; i < 6; i++) step(1, 0, 0, 32'h0000_0000, 0, 1, "R4 zero_seed");
      // R3: re-enable restarts at the starting value
      step(0, 1, 0, 32'h0000_0042, 0, 0, "R2 idle");
      for (int i = 0; i < 3; i++) step(1, 1, 0, 32'h0000_0042, 0, 1, "R3 restart");
      for (int i = 0; i < 3; i++) step(0, 0, 0, 32'h0000_0000, 0, 0, "R2 drain");
      repeat (3) @(posedge clk);
      #2;
      summary();
   end
endmodule